// File: doc/BRIEF.md
# Streaming 3x3 Weighted Blur Filter

This block smooths a raster image stream with a fixed 3x3 weighted kernel. Pixels of a 64 x 64 frame arrive one per accepted cycle in raster order. Two row stores keep the previous two rows, and a small register window keeps the two previous columns of the neighbourhood. All nine taps are multiplied and summed in one cycle in 16-bit unsigned arithmetic. The sum is scaled down by 256 and produced as one 8-bit pixel.

Only neighbourhoods that lie completely inside the frame are produced, so each frame yields 62 x 62 output pixels. Each output pixel is named after the top-left corner of its window. A start-of-frame flag on the input puts the position counters back to the origin. The output carries end-of-line and end-of-frame markers. When the consumer is not ready, the whole pipe holds, and no input is taken.

Top module: `stencil_blur3`

## Requirements
- R1: While reset is held and after it is released, outValid, outEol and outEof are low, and the next accepted pixel is taken as position (0,0).
- R2: inReady always equals outReady, so no input pixel is accepted in a cycle where outReady is low.
- R3: While outValid is high and outReady is low, outValid, outPix, outEol and outEof keep their values.
- R4: Output pixel (x,y) is bits [15:8] of the 16-bit wrapping sum of weight times input pixel over columns x..x+2 and rows y..y+2. The weight is 37 at the centre, 30 at the four edge-middle taps and 24 at the four corners.
- R5: Per 64 x 64 frame, exactly the 62 x 62 interior windows are emitted, in raster order. Input rows 0-1 and input columns 0-1 produce no output.
- R6: outEol is high with every output whose column is 61. outEof is high only with output (61,61), and it is always high together with outEol.
- R7: An accepted pixel with inSof high is placed at (0,0), whatever the counters held before.
- R8: A frame of all-255 pixels gives 252 at every output, with no saturation (sum 64515).
- R9: Accepting the input pixel at (x+2,y+2) makes output (x,y) valid in the next cycle. outValid never rises without an accepted pixel in the cycle before.
- R10: The position counters wrap from (63,63) back to (0,0), so a frame sent with no inSof still filters correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block can take an input pixel |
| inPix | input | 8 | Input pixel value |
| inSof | input | 1 | Marks the first pixel of a frame |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the output pixel |
| outPix | output | 8 | Filtered pixel value |
| outEol | output | 1 | Output pixel is the last of its row |
| outEof | output | 1 | Output pixel is the last of its frame |

## Verification
A row store that is written at the wrong column, or shifted at the wrong point, corrupts outPix as soon as the third row begins. A column counter that is off by one moves outEol away from column 61 in the first output row. The reference model compares every transferred pixel in the cycle it is handed over, so any such fault shows at the first affected output. A stall fault shows one cycle after outReady drops: either the output changes while held, or an input pixel is lost and all later positions shift.

// File: rtl/blur_pkg.sv
package blur_pkg;
  parameter int IMG_W      = 64;
  parameter int IMG_H      = 64;
  parameter int PIX_W      = 8;
  parameter int ACC_W      = 16;
  parameter int NORM_SHIFT = 8;
  parameter int KSIZE      = 3;

  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);

  // control -> datapath strobes
  typedef struct packed {
    logic             accept;
    logic             emit;
    logic [COL_W-1:0] col;
  } blurCtl_t;

  // centre 37, edge-middle taps 30, corners 24
  function automatic logic [ACC_W-1:0] tapWeight(input int r, input int c);
    if (r == 1 && c == 1) return ACC_W'(37);
    else if (r == 1 || c == 1) return ACC_W'(30);
    else return ACC_W'(24);
  endfunction
endpackage

// File: rtl/blur_ctrl.sv
module blur_ctrl
  import blur_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inSof,
  input  logic     outReady,
  output logic     inReady,
  output blurCtl_t ctl,
  output logic     outValid,
  output logic     outEol,
  output logic     outEof
);
  logic [COL_W-1:0] colQ, curCol;
  logic [ROW_W-1:0] rowQ, curRow;
  logic accept, emit, lastCol, lastRow;

  assign inReady = outReady;            // whole pipe stalls with the consumer
  assign accept  = inValid & outReady;
  assign curCol  = inSof ? '0 : colQ;
  assign curRow  = inSof ? '0 : rowQ;
  assign lastCol = (curCol == COL_W'(IMG_W - 1));
  assign lastRow = (curRow == ROW_W'(IMG_H - 1));
  assign emit    = accept && (curCol >= COL_W'(KSIZE - 1)) && (curRow >= ROW_W'(KSIZE - 1));

  assign ctl.accept = accept;
  assign ctl.emit   = emit;
  assign ctl.col    = curCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ     <= '0;
      rowQ     <= '0;
      outValid <= 1'b0;
      outEol   <= 1'b0;
      outEof   <= 1'b0;
    end else begin
      if (outReady) begin
        outValid <= emit;
        outEol   <= emit && lastCol;
        outEof   <= emit && lastCol && lastRow;
      end
      if (accept) begin
        if (lastCol) begin
          colQ <= '0;
          rowQ <= lastRow ? '0 : curRow + ROW_W'(1);
        end else begin
          colQ <= curCol + COL_W'(1);
          rowQ <= curRow;
        end
      end
    end
  end
endmodule

// File: rtl/blur_datapath.sv
module blur_datapath
  import blur_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  blurCtl_t         ctl,
  input  logic [PIX_W-1:0] inPix,
  output logic [PIX_W-1:0] outPix
);
  logic [PIX_W-1:0] rowPrev1 [IMG_W];   // row y-1
  logic [PIX_W-1:0] rowPrev2 [IMG_W];   // row y-2
  logic [PIX_W-1:0] winHist  [KSIZE][KSIZE-1];
  logic [PIX_W-1:0] newCol   [KSIZE];
  logic [PIX_W-1:0] tap      [KSIZE][KSIZE];
  logic [ACC_W-1:0] prod     [KSIZE][KSIZE];
  logic [ACC_W-1:0] sum;

  assign newCol[0] = rowPrev2[ctl.col];
  assign newCol[1] = rowPrev1[ctl.col];
  assign newCol[2] = inPix;

  always_ff @(posedge clk) begin
    if (ctl.accept) begin
      rowPrev1[ctl.col] <= inPix;
      rowPrev2[ctl.col] <= rowPrev1[ctl.col];
    end
  end

  for (genvar r = 0; r < KSIZE; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (ctl.accept) begin
        for (int c = 0; c < KSIZE - 2; c++) winHist[r][c] <= winHist[r][c+1];
        winHist[r][KSIZE-2] <= newCol[r];
      end
    end
    for (genvar c = 0; c < KSIZE; c++) begin : g_col
      if (c == KSIZE - 1) begin : g_new
        assign tap[r][c] = newCol[r];
      end else begin : g_old
        assign tap[r][c] = winHist[r][c];
      end
      assign prod[r][c] = ACC_W'(tap[r][c]) * tapWeight(r, c);
    end
  end

  always_comb begin
    sum = '0;
    for (int r = 0; r < KSIZE; r++)
      for (int c = 0; c < KSIZE; c++)
        sum = sum + prod[r][c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outPix <= '0;
    else if (ctl.emit) outPix <= sum[NORM_SHIFT +: PIX_W];
  end
endmodule

// File: rtl/stencil_blur3.sv
module stencil_blur3
  import blur_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inSof,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outPix,
  output logic             outEol,
  output logic             outEof
);
  blurCtl_t ctl;

  blur_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .outReady(outReady), .inReady(inReady), .ctl(ctl),
    .outValid(outValid), .outEol(outEol), .outEof(outEof)
  );

  blur_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inPix(inPix), .outPix(outPix)
  );
endmodule

// File: rtl/blur_checker.sv
module blur_checker
  import blur_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPix,
  input logic             outEol,
  input logic             outEof
);
  a_r1_reset_clears: assert property (@(posedge clk) !rstN |=> !outValid && !outEol && !outEof);

  a_r2_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !inReady);

  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPix) && $stable(outEol) && $stable(outEof));

  a_r6_eof_with_eol: assert property (@(posedge clk) disable iff (!rstN)
    outEof |-> outValid && outEol);

  a_r9_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));
endmodule

bind stencil_blur3 blur_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPix(outPix),
  .outEol(outEol), .outEof(outEof)
);

// File: tb/stencil_blur3_tb.sv
module stencil_blur3_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int H = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, outReady = 1'b0;
  logic [7:0] inPix = '0;
  logic inReady, outValid, outEol, outEof;
  logic [7:0] outPix;

  always #(CLK_PERIOD/2) clk = ~clk;

  stencil_blur3 u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPix(inPix), .inSof(inSof), .outValid(outValid), .outReady(outReady),
    .outPix(outPix), .outEol(outEol), .outEof(outEof)
  );

  int total = 0, bad = 0;
  int img [H][W];
  int mCol = 0, mRow = 0;
  int qPix[$], qEol[$], qEof[$];
  int outCount = 0;
  string pixTag = "R4";
  bit expectNext = 0;
  bit heldValid = 0;
  int heldPix = 0, heldEol = 0, heldEof = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // weights: centre 37, edge-middle 30, corners 24; 16-bit wrap, >>8
  function automatic int refPix(input int x, input int y);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        int w = (r == 1 && c == 1) ? 37 : ((r == 1 || c == 1) ? 30 : 24);
        s += w * img[y+r][x+c];
      end
    return (s & 16'hFFFF) >> 8;
  endfunction

  task automatic modelAccept(input int pix, input bit sof);
    if (sof) begin mCol = 0; mRow = 0; end
    img[mRow][mCol] = pix;
    if (mCol >= 2 && mRow >= 2) begin
      qPix.push_back(refPix(mCol-2, mRow-2));
      qEol.push_back(mCol == W-1);
      qEof.push_back(mCol == W-1 && mRow == H-1);
      expectNext = 1;
    end
    if (mCol == W-1) begin
      mCol = 0;
      mRow = (mRow == H-1) ? 0 : mRow + 1;
    end else mCol++;
  endtask

  task automatic observe();
    check(inReady == outReady, "R2", inReady, outReady);
    if (heldValid) begin
      check(outValid && outPix == heldPix && outEol == heldEol && outEof == heldEof,
            "R3", outPix, heldPix);
    end
    if (expectNext) begin
      check(outValid == 1'b1, "R9", outValid, 1);
      expectNext = 0;
    end
    heldValid = outValid && !outReady;
    heldPix = outPix; heldEol = outEol; heldEof = outEof;
    if (outValid && outReady) begin
      outCount++;
      if (qPix.size() == 0) begin
        check(1'b0, "R5 unexpected output", outPix, -1);
      end else begin
        int ep = qPix.pop_front();
        int ee = qEol.pop_front();
        int ef = qEof.pop_front();
        check(outPix == ep, pixTag, outPix, ep);
        check(outEol == ee, "R6 eol", outEol, ee);
        check(outEof == ef, "R6 eof", outEof, ef);
        check(!outEof || outEol, "R6 eof-eol", outEol, 1);
      end
    end
  endtask

  // mode 0: random pixels, mode 1: all 255
  task automatic runPixels(input int n, input int mode, input bit sofFirst, input int readyPct);
    int sent = 0;
    int pix = (mode == 1) ? 255 : int'($urandom_range(0, 255));
    while (sent < n) begin
      outReady = ($urandom_range(0, 99) < readyPct);
      inValid  = ($urandom_range(0, 3) != 0);
      inPix    = 8'(pix);
      inSof    = sofFirst && (sent == 0);
      #1;
      observe();
      if (inValid && inReady) begin
        modelAccept(pix, inSof);
        sent++;
        pix = (mode == 1) ? 255 : int'($urandom_range(0, 255));
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    inSof = 1'b0;
  endtask

  task automatic drain(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      outReady = 1'b1;
      #1;
      observe();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outEol == 1'b0 && outEof == 1'b0, "R1 after reset", outValid, 0);

    // R1/R4/R5/R6: first frame, no sof, counters start at origin; random stalls (R2/R3)
    runPixels(W*H, 0, 1'b0, 70);
    drain(4);
    // R8 and R10: all-255 frame with no sof, relying on counter wrap
    pixTag = "R8 all-255";
    runPixels(W*H, 1, 1'b0, 100);
    drain(4);
    pixTag = "R4";
    // R7: partial frame, then a new frame restarted by sof
    runPixels(150, 0, 1'b1, 80);
    pixTag = "R7 after sof";
    runPixels(W*H, 0, 1'b1, 50);
    drain(6);

    check(qPix.size() == 0, "R5 missing outputs", qPix.size(), 0);
    check(outCount == 3*62*62 + 20, "R5 output count", outCount, 3*62*62 + 20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule